// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Page Writer

This block sits on the host side of a serial flash link. It writes whole pages into the flash array. A local client gives it a page number, then streams the bytes of that page. Both transfers use a valid/ready handshake. For each page the block waits until the flash reports ready. It then lowers chip select and shifts out a program-through-buffer frame, most significant bit first, in SPI mode 0. The frame holds an 8-bit command, a 24-bit address and the page bytes. The block raises chip select to start the internal program, watches the busy line go active, and pulses `done`.

The flash has two internal page buffers. The block alternates between them page by page, selecting each one through its own command code. The buffer just handed to the array is therefore never the one being refilled next. The address field has three reserved zero bits, then the page index, then a byte offset that is always zero, because every page is written from its first byte. A divider parameter sets the serial clock, and its default gives 10 MHz from a 100 MHz system clock.

Top module: `flash_pgm_seq`

## Requirements
- R1: During and right after reset, `spi_cs_n` is 1, `spi_sck` is 0, `done` is 0, `pg_ready` is 1 and `dat_ready` is 0.
- R2: Each frame keeps `spi_cs_n` low for exactly 32 + 8*PAGE_BYTES rising edges of `spi_sck`. Bits are taken MSB first on rising edges, in this order: 8 command bits, then 3 zero bits, then the 12-bit page number, then 9 zero bits, then the page bytes in the order they were accepted.
- R3: The first frame after reset carries command 8'h82, which selects buffer 0. Each later frame switches to the other buffer: 8'h85, 8'h82, 8'h85, and so on.
- R4: `spi_sck` is 0 whenever `spi_cs_n` is 1. `spi_mosi` changes only while `spi_sck` is low.
- R5: Every high phase of `spi_sck` lasts exactly CLK_DIV system clocks. Every low phase inside a frame lasts at least CLK_DIV system clocks.
- R6: `spi_cs_n` falls only after the synchronised `flash_rdy` has been seen high. A new frame never starts while the flash is busy.
- R7: `done` is a single-cycle pulse. It comes once per frame, after `spi_cs_n` has risen and the synchronised `flash_rdy` has been seen low.
- R8: `dat_ready` is high only while `spi_cs_n` is low. `dat_ready` and `pg_ready` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_valid | input | 1 | Page number offered |
| pg_ready | output | 1 | Block idle and able to take a page number |
| pg_num | input | PAGE_W | Page index to program |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte taken on this clock when valid |
| dat_byte | input | 8 | Page data byte |
| done | output | 1 | One-cycle pulse after the program has started |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data toward the flash |
| flash_rdy | input | 1 | Ready/busy from the flash, low while busy |

## Verification
The assertions assume `flash_rdy` behaves like a real flash. It stays high while idle and drops within a few clocks after chip select rises. It then stays low for many clocks and goes high again. They also assume the client holds `pg_num` and `dat_byte` steady while valid is high. The bench's flash model lowers ready three cycles after each frame ends and keeps it low for at least a hundred cycles. The client drives its inputs on falling edges and holds them until the handshake completes. The next page is always offered while the previous program is still busy, so the wait-for-ready path is exercised on every frame after the first.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam logic [7:0] OPC_PROG_BUF0 = 8'h82;
  localparam logic [7:0] OPC_PROG_BUF1 = 8'h85;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_HDR,
    ST_DATA,
    ST_CLOSE,
    ST_BUSY
  } seq_state_t;
endpackage

// File: rtl/fps_sync.sv
module fps_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fps_shifter.sv
// Byte-wide mode-0 serializer: SCK idles low, data moves on the falling edge.
module fps_shifter #(
  parameter int CLK_DIV = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [7:0] ld_byte,
  output logic       busy,
  output logic       sck,
  output logic       mosi
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [7:0]       sr;
  logic [2:0]       bit_idx;
  logic [DIV_W-1:0] div;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      bit_idx <= '0;
      div     <= '0;
      busy    <= 1'b0;
      sck     <= 1'b0;
    end else if (ld && !busy) begin
      sr      <= ld_byte;
      bit_idx <= '0;
      div     <= '0;
      busy    <= 1'b1;
      sck     <= 1'b0;
    end else if (busy) begin
      if (div == DIV_LAST) begin
        div <= '0;
        if (!sck) begin
          sck <= 1'b1;
        end else begin
          sck <= 1'b0;
          if (bit_idx == 3'd7) begin
            busy <= 1'b0;
          end else begin
            bit_idx <= bit_idx + 3'd1;
            sr      <= {sr[6:0], 1'b0};
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  assign mosi = sr[7];
endmodule

// File: rtl/fps_seq.sv
module fps_seq
  import fps_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 9,
  parameter int RSV_W      = 3,
  parameter int PAGE_BYTES = 264
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_valid,
  input  logic [PAGE_W-1:0] pg_num,
  output logic              pg_ready,
  input  logic              dat_valid,
  input  logic [7:0]        dat_byte,
  output logic              dat_ready,
  input  logic              sh_busy,
  output logic              sh_ld,
  output logic [7:0]        sh_byte,
  input  logic              rdy_s,
  output logic              cs_n,
  output logic              done
);
  localparam int HDR_W     = 8 + RSV_W + PAGE_W + BYTE_W;
  localparam int HDR_BYTES = HDR_W / 8;
  localparam int HIDX_W    = $clog2(HDR_BYTES);
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1);
  localparam logic [HIDX_W-1:0] HDR_LAST = HIDX_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0]  DAT_LAST = CNT_W'(PAGE_BYTES - 1);

  seq_state_t        st;
  logic [PAGE_W-1:0] page_q;
  logic [HDR_W-1:0]  hdr_sr;
  logic [HIDX_W-1:0] hcnt;
  logic [CNT_W-1:0]  dcnt;
  logic              buf_sel;
  logic [7:0]        opc;
  logic              dat_take;

  assign opc      = buf_sel ? OPC_PROG_BUF1 : OPC_PROG_BUF0;
  assign pg_ready = (st == ST_IDLE);

  always_comb begin
    dat_ready = (st == ST_DATA) && !sh_busy;
    dat_take  = dat_ready && dat_valid;
    sh_ld     = ((st == ST_HDR) && !sh_busy) || dat_take;
    sh_byte   = (st == ST_HDR) ? hdr_sr[HDR_W-1 -: 8] : dat_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      page_q  <= '0;
      hdr_sr  <= '0;
      hcnt    <= '0;
      dcnt    <= '0;
      buf_sel <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (pg_valid) begin
          page_q <= pg_num;
          st     <= ST_WAIT_RDY;
        end
        ST_WAIT_RDY: if (rdy_s) begin
          cs_n   <= 1'b0;
          hdr_sr <= {opc, {RSV_W{1'b0}}, page_q, {BYTE_W{1'b0}}};
          hcnt   <= '0;
          st     <= ST_HDR;
        end
        ST_HDR: if (!sh_busy) begin
          hdr_sr <= hdr_sr << 8;
          if (hcnt == HDR_LAST) begin
            dcnt <= '0;
            st   <= ST_DATA;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_DATA: if (dat_take) begin
          if (dcnt == DAT_LAST) st <= ST_CLOSE;
          else                  dcnt <= dcnt + 1'b1;
        end
        ST_CLOSE: if (!sh_busy) begin
          cs_n    <= 1'b1;
          buf_sel <= ~buf_sel;
          st      <= ST_BUSY;
        end
        ST_BUSY: if (!rdy_s) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq #(
  parameter int PAGE_W      = 12,
  parameter int BYTE_W      = 9,
  parameter int RSV_W       = 3,
  parameter int PAGE_BYTES  = 264,
  parameter int CLK_DIV     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_valid,
  output logic              pg_ready,
  input  logic [PAGE_W-1:0] pg_num,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [7:0]        dat_byte,
  output logic              done,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              flash_rdy
);
  logic       rdy_s;
  logic       sh_busy;
  logic       sh_ld;
  logic [7:0] sh_byte;

  fps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(flash_rdy), .q(rdy_s)
  );

  fps_seq #(
    .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .RSV_W(RSV_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst),
    .pg_valid(pg_valid), .pg_num(pg_num), .pg_ready(pg_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
    .sh_busy(sh_busy), .sh_ld(sh_ld), .sh_byte(sh_byte),
    .rdy_s(rdy_s), .cs_n(spi_cs_n), .done(done)
  );

  fps_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .ld(sh_ld), .ld_byte(sh_byte),
    .busy(sh_busy), .sck(spi_sck), .mosi(spi_mosi)
  );
endmodule

// File: rtl/fps_checker.sv
module fps_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic rdy_s,
  input logic done,
  input logic pg_ready,
  input logic dat_ready
);
  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r6_cs_waits_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(rdy_s));

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !$past(rdy_s)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_ready_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pg_ready && dat_ready));

  a_r8_data_in_frame: assert property (@(posedge clk) disable iff (rst)
    dat_ready |-> !cs_n);
endmodule

bind flash_pgm_seq fps_checker u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
  .rdy_s(rdy_s), .done(done), .pg_ready(pg_ready), .dat_ready(dat_ready)
);

// File: tb/flash_pgm_seq_bench.sv
module flash_pgm_seq_bench;
  localparam int PW    = 12;
  localparam int PB    = 5;
  localparam int DIV   = 3;
  localparam int NPG   = 4;
  localparam int FBITS = 32 + 8 * PB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg_valid = 1'b0, dat_valid = 1'b0, flash_rdy = 1'b1;
  logic [PW-1:0] pg_num = '0;
  logic [7:0] dat_byte = '0;
  logic pg_ready, dat_ready, done, spi_sck, spi_cs_n, spi_mosi;

  always #5 clk = ~clk;

  flash_pgm_seq #(.PAGE_W(PW), .PAGE_BYTES(PB), .CLK_DIV(DIV)) u_flash_pgm_seq (
    .clk(clk), .rst(rst), .pg_valid(pg_valid), .pg_ready(pg_ready),
    .pg_num(pg_num), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_byte(dat_byte), .done(done), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .flash_rdy(flash_rdy)
  );

  int n_chk = 0, n_fail = 0;
  int frames = 0, dones = 0, cyc = 0;
  int v_r4 = 0, v_r5 = 0, v_r8 = 0;
  logic [PW-1:0] pages [NPG] = '{12'hA5C, 12'h001, 12'hFFF, 12'h800};

  function automatic logic [7:0] data_of(int p, int i);
    return 8'((p * 37 + i * 11 + 60) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Reference monitor and flash model, evaluated once per clock at negedge
  logic fbits [$];
  logic prev_sck = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0, prev_done = 1'b0;
  int run = 0, rdy_hi = 0, rdy_lo = 0, bdelay = 0, bleft = 0;
  bit pending = 0;

  function automatic logic [63:0] field(int s, int n);
    logic [63:0] v = '0;
    for (int k = 0; k < n; k++) v = {v[62:0], fbits[s + k]};
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (cyc > 150000) begin
        chk(0, "R2", "watchdog expired", 64'(cyc), 64'd150000);
        finish_run();
      end
      rdy_hi = flash_rdy ? rdy_hi + 1 : 0;
      rdy_lo = flash_rdy ? 0 : rdy_lo + 1;
      // R4 and R8 protocol rules
      if (spi_cs_n && spi_sck) begin
        v_r4++; $display("FAIL R4 sck high while deselected: actual 1 expected 0");
      end
      if (prev_sck && spi_sck && spi_mosi != prev_mosi) begin
        v_r4++; $display("FAIL R4 mosi moved while sck high: actual %0b expected %0b", spi_mosi, prev_mosi);
      end
      if ((dat_ready && spi_cs_n) || (dat_ready && pg_ready)) begin
        v_r8++; $display("FAIL R8 dat_ready outside frame: actual 1 expected 0");
      end
      // R5 phase widths
      if (spi_sck != prev_sck) begin
        if (prev_sck && run != DIV) begin
          v_r5++; $display("FAIL R5 high phase: actual %0d expected %0d", run, DIV);
        end
        if (!prev_sck && !spi_cs_n && run < DIV) begin
          v_r5++; $display("FAIL R5 low phase: actual %0d expected >= %0d", run, DIV);
        end
        run = 1;
      end else run++;
      if (!prev_sck && spi_sck && !spi_cs_n) fbits.push_back(spi_mosi);
      // R6 frame start
      if (prev_cs && !spi_cs_n) begin
        chk(rdy_hi >= 2, "R6", "cs fell without ready", 64'(rdy_hi), 64'd2);
        fbits.delete();
      end
      // frame end: R2, R3
      if (!prev_cs && spi_cs_n) begin
        chk(fbits.size() == FBITS, "R2", "frame bit count", 64'(fbits.size()), 64'(FBITS));
        if (fbits.size() == FBITS && frames < NPG) begin
          logic [63:0] d_act = '0, d_exp = '0;
          chk(field(0, 8) == ((frames % 2) ? 64'h85 : 64'h82), "R3", "opcode",
              field(0, 8), (frames % 2) ? 64'h85 : 64'h82);
          chk(field(8, 24) == 64'(pages[frames]) << 9, "R2", "address field",
              field(8, 24), 64'(pages[frames]) << 9);
          for (int i = 0; i < PB; i++) begin
            d_act = {d_act[55:0], field(32 + 8 * i, 8)[7:0]};
            d_exp = {d_exp[55:0], data_of(frames, i)};
          end
          chk(d_act == d_exp, "R2", "page data", d_act, d_exp);
        end
        frames++;
        pending = 1;
        bdelay = 3;
      end
      // R7 done pulse
      if (done) begin
        chk(pending && rdy_lo >= 2, "R7", "done before busy seen", 64'(rdy_lo), 64'd2);
        chk(!prev_done, "R7", "done longer than one cycle", 64'(prev_done), 64'd0);
        pending = 0;
        dones++;
      end
      // flash model: busy starts 3 cycles after deselect
      if (bdelay > 0) begin
        bdelay--;
        if (bdelay == 0) begin flash_rdy = 1'b0; bleft = 100 + 40 * frames; end
      end else if (bleft > 0) begin
        bleft--;
        if (bleft == 0) flash_rdy = 1'b1;
      end
      prev_sck = spi_sck; prev_cs = spi_cs_n; prev_mosi = spi_mosi; prev_done = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", 64'(spi_cs_n), 64'd1);
    chk(spi_sck == 1'b0, "R1", "sck in reset", 64'(spi_sck), 64'd0);
    chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    chk(pg_ready && !dat_ready, "R1", "ready flags in reset", {62'd0, pg_ready, dat_ready}, 64'd2);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n && pg_ready, "R1", "idle after reset", {62'd0, spi_cs_n, pg_ready}, 64'd3);
    for (int p = 0; p < NPG; p++) begin
      pg_valid = 1'b1; pg_num = pages[p];
      while (!pg_ready) @(negedge clk);
      @(posedge clk); @(negedge clk);
      pg_valid = 1'b0;
      for (int i = 0; i < PB; i++) begin
        repeat ((i + p) % 3) @(negedge clk);
        dat_valid = 1'b1; dat_byte = data_of(p, i);
        while (!dat_ready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        dat_valid = 1'b0;
      end
      while (dones <= p) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk(frames == NPG, "R2", "frame count", 64'(frames), 64'(NPG));
    chk(dones == NPG, "R7", "done count", 64'(dones), 64'(NPG));
    chk(v_r4 == 0, "R4", "mode-0 violations", 64'(v_r4), 64'd0);
    chk(v_r5 == 0, "R5", "phase width violations", 64'(v_r5), 64'd0);
    chk(v_r8 == 0, "R8", "ready overlap violations", 64'(v_r8), 64'd0);
    finish_run();
  end
endmodule